// File: doc/BRIEF.md
# Atomic Multi-Byte Register Bank

This block is a byte-wide register file that sits behind a plain parallel host bus: an address, a write strobe, a read strobe, 8-bit write data and registered 8-bit read data. It holds a control byte, a configuration value several bytes wide, a byte of sticky event flags, and a read-only window onto a wide live counter that the surrounding logic supplies.

Values wider than one byte are handled so that the host never sees a half-updated word. A wide configuration value is staged byte by byte and takes effect only after every byte has been written in ascending order with no other access in between. Reading the lowest byte of the wide live counter takes a snapshot, and the other bytes of the counter then return that snapshot. Event flags are sticky and are cleared by writing ones. A loss-of-activity alarm output has a programmable active level and a programmable drive-or-release state when it is inactive.

Top module: `regbank_top`

## Requirements
- R1: After synchronous reset the control byte equals CTRL_DEFAULT, the configuration value equals CFG_DEFAULT, all event flags are 0, read data is 0x00, and with the loss input low the alarm and its output enable are both low for the default control byte 0x01.
- R2: A write to the control address replaces all 8 bits of the control byte, and a read returns it. A read returns its byte on the rising edge that samples the strobe, and read data holds until the next read. When both strobes are high in one cycle only the write is performed.
- R3: The configuration value (byte k at address CFG_BASE+k, byte 0 least significant) changes only on the write to its highest byte, and only when bytes 0 to CFG_BYTES-1 were written in ascending order. Idle cycles between these writes are allowed. Reads of configuration addresses return the value in force, never the staged bytes.
- R4: Any other access (a read anywhere, a write elsewhere, or a write to a configuration byte other than the expected one) between the writes of a sequence discards the partial sequence, and the value in force stays unchanged. A write to byte 0 always starts a new sequence.
- R5: A read of live-counter byte 0 (address MON_BASE) returns the current low byte and captures the whole counter. Later reads of bytes 1 to MON_BYTES-1 return the captured bytes while the capture is held.
- R6: The capture is released by a read of the highest counter byte or by any access outside the counter's read window, including any write. Reads of counter bytes 1 and up without a held capture return the live bytes.
- R7: Each bit of the event byte at STS_ADDR is set by a high on the matching event input and stays set. Writing 1 to a bit clears it, writing 0 leaves it alone, and an event in the same cycle as the clear keeps the bit set.
- R8: Reads of undefined addresses return 0x00. Writes to undefined addresses, to the identity address and to the counter window change no register.
- R9: The alarm output and its enable update one cycle after the loss input. Control bit 0 gives the active level (1 = active high). Control bit 1 set keeps the output enabled while it is inactive, and clear releases it. While loss is high the output is always enabled.
- R10: A read of ID_ADDR returns ID_VALUE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe, one access per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| evt_i | input | 8 | Event pulses feeding the sticky flags |
| los_i | input | 1 | Live loss-of-activity condition |
| mon_i | input | MON_BYTES*8 | Live wide counter value |
| cfg_o | output | CFG_BYTES*8 | Configuration value in force |
| alarm_o | output | 1 | Alarm level |
| alarm_oe_o | output | 1 | Alarm output enable (0 = released) |

## Verification
The bench builds the block with a three-byte configuration value and a four-byte counter window, both larger than the two-byte defaults. With three bytes there is a middle configuration byte, so an out-of-order write and a restart at byte 0 in the middle of a sequence can both be tested. With four bytes there are two middle counter bytes, so reads of captured bytes before the releasing top-byte read can be tested in any order. A 5-bit address leaves half the space undefined for the ignore and zero-read cases.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef logic [7:0] reg_byte_t;

  // Width of a byte index inside a group of n bytes, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/regbank_wr_stage.sv
module regbank_wr_stage #(
  parameter int                   BYTES   = 2,
  parameter int                   IW      = 1,
  parameter logic [BYTES*8-1:0]   DEFAULT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,     // write to a byte of this group
  input  logic [IW-1:0]      idx_i,
  input  logic [7:0]         wdata_i,
  input  logic               other_i,   // any access that is not a group write
  output logic [BYTES*8-1:0] value_o
);
  import regbank_pkg::*;

  localparam logic [IW-1:0] TOP = IW'(BYTES - 1);

  logic [IW-1:0]      next_q;
  reg_byte_t          stage_q [BYTES];
  logic [BYTES*8-1:0] value_q;
  logic [BYTES*8-1:0] commit_val;
  logic               in_order;
  logic               restart;
  logic               stage_we;

  assign in_order = hit_i && (idx_i == next_q);
  assign restart  = hit_i && (idx_i == '0);
  assign stage_we = (in_order || restart) && (idx_i != TOP);

  // Staging bytes carry no reset so they can map onto distributed memory.
  always_ff @(posedge clk) begin
    if (stage_we) stage_q[idx_i] <= wdata_i;
  end

  always_comb begin
    for (int b = 0; b < BYTES - 1; b++) commit_val[b*8 +: 8] = stage_q[b];
    commit_val[(BYTES-1)*8 +: 8] = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q  <= '0;
      value_q <= DEFAULT;
    end else if (in_order) begin
      if (idx_i == TOP) begin
        value_q <= commit_val;
        next_q  <= '0;
      end else begin
        next_q <= idx_i + IW'(1);
      end
    end else if (restart) begin
      next_q <= IW'(1);
    end else if (hit_i || other_i) begin
      next_q <= '0;
    end
  end

  assign value_o = value_q;

  assert_commit_on_top_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(value_q) |-> $past(hit_i && (idx_i == TOP)));

  assert_next_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    next_q <= TOP);

  assert_abort_on_other_R4: assert property (@(posedge clk) disable iff (rst)
    other_i |=> (next_q == '0));

endmodule

// File: rtl/regbank_rd_freeze.sv
module regbank_rd_freeze #(
  parameter int BYTES = 2,
  parameter int IW    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,     // read of a byte of this group
  input  logic [IW-1:0]      idx_i,
  input  logic               other_i,   // any access that is not a group read
  input  logic [BYTES*8-1:0] live_i,
  output logic [7:0]         byte_o
);
  localparam logic [IW-1:0] TOP = IW'(BYTES - 1);

  logic               frozen_q;
  logic [BYTES*8-1:0] snap_q;
  logic               arm;

  assign arm = hit_i && (idx_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_q <= 1'b0;
      snap_q   <= '0;
    end else if (arm) begin
      frozen_q <= 1'b1;
      snap_q   <= live_i;
    end else if ((hit_i && (idx_i == TOP)) || other_i) begin
      frozen_q <= 1'b0;
    end
  end

  always_comb begin
    if (frozen_q && (idx_i != '0)) byte_o = snap_q[{idx_i, 3'b000} +: 8];
    else                           byte_o = live_i[{idx_i, 3'b000} +: 8];
  end

  assert_snapshot_held_R5: assert property (@(posedge clk) disable iff (rst)
    (frozen_q && !arm) |=> $stable(snap_q));

  assert_release_on_other_R6: assert property (@(posedge clk) disable iff (rst)
    other_i |=> !frozen_q);

  assert_release_on_top_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_i && (idx_i == TOP) && (TOP != '0)) |=> !frozen_q);

endmodule

// File: rtl/regbank_sticky.sv
module regbank_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~clr_i) | evt_i;
  end

  assign sts_o = sts_q;

  assert_event_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  assert_unclear_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_q != '0) |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
  parameter int                     ADDR_W       = 5,
  parameter int                     ID_ADDR      = 0,
  parameter int                     CTRL_ADDR    = 1,
  parameter int                     CFG_BASE     = 4,
  parameter int                     CFG_BYTES    = 2,
  parameter int                     STS_ADDR     = 8,
  parameter int                     MON_BASE     = 12,
  parameter int                     MON_BYTES    = 2,
  parameter logic [7:0]             ID_VALUE     = 8'h6B,
  parameter logic [7:0]             CTRL_DEFAULT = 8'h01,
  parameter logic [CFG_BYTES*8-1:0] CFG_DEFAULT  = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [7:0]             evt_i,
  input  logic                   los_i,
  input  logic [MON_BYTES*8-1:0] mon_i,
  output logic [CFG_BYTES*8-1:0] cfg_o,
  output logic                   alarm_o,
  output logic                   alarm_oe_o
);
  import regbank_pkg::*;

  localparam int CFG_IW = idx_width(CFG_BYTES);
  localparam int MON_IW = idx_width(MON_BYTES);

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] cfg_off, mon_off;
  logic              in_cfg, in_mon, is_id, is_ctrl, is_sts, defined;
  logic              rd_act, any_acc;
  logic              cfg_hit, cfg_other, mon_hit, mon_other;
  logic [CFG_IW-1:0] cfg_idx;
  logic [MON_IW-1:0] mon_idx;

  assign cfg_off = addr_i - ADDR_W'(CFG_BASE);
  assign mon_off = addr_i - ADDR_W'(MON_BASE);
  assign in_cfg  = (addr_i >= ADDR_W'(CFG_BASE)) && (cfg_off < ADDR_W'(CFG_BYTES));
  assign in_mon  = (addr_i >= ADDR_W'(MON_BASE)) && (mon_off < ADDR_W'(MON_BYTES));
  assign is_id   = addr_i == ADDR_W'(ID_ADDR);
  assign is_ctrl = addr_i == ADDR_W'(CTRL_ADDR);
  assign is_sts  = addr_i == ADDR_W'(STS_ADDR);
  assign defined = is_id || is_ctrl || is_sts || in_cfg || in_mon;
  assign cfg_idx = cfg_off[CFG_IW-1:0];
  assign mon_idx = mon_off[MON_IW-1:0];

  assign rd_act    = rd_en_i && !wr_en_i;
  assign any_acc   = rd_en_i || wr_en_i;
  assign cfg_hit   = wr_en_i && in_cfg;
  assign cfg_other = any_acc && !cfg_hit;
  assign mon_hit   = rd_act && in_mon;
  assign mon_other = any_acc && !mon_hit;

  // ---------------- wide configuration value ----------------
  regbank_wr_stage #(
    .BYTES   (CFG_BYTES),
    .IW      (CFG_IW),
    .DEFAULT (CFG_DEFAULT)
  ) u_cfg_stage (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (cfg_hit),
    .idx_i   (cfg_idx),
    .wdata_i (wdata_i),
    .other_i (cfg_other),
    .value_o (cfg_o)
  );

  // ---------------- wide live counter window ----------------
  reg_byte_t mon_byte;

  regbank_rd_freeze #(
    .BYTES (MON_BYTES),
    .IW    (MON_IW)
  ) u_mon_freeze (
    .clk     (clk),
    .rst     (rst),
    .hit_i   (mon_hit),
    .idx_i   (mon_idx),
    .other_i (mon_other),
    .live_i  (mon_i),
    .byte_o  (mon_byte)
  );

  // ---------------- sticky event flags ----------------
  reg_byte_t sts_q, sts_clr;

  assign sts_clr = (wr_en_i && is_sts) ? wdata_i : 8'h00;

  regbank_sticky #(.W(8)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_i),
    .clr_i (sts_clr),
    .sts_o (sts_q)
  );

  // ---------------- control byte ----------------
  reg_byte_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)                    ctrl_q <= CTRL_DEFAULT;
    else if (wr_en_i && is_ctrl) ctrl_q <= wdata_i;
  end

  // ---------------- read path ----------------
  reg_byte_t rd_byte, rdata_q;

  always_comb begin
    if (is_id)        rd_byte = ID_VALUE;
    else if (is_ctrl) rd_byte = ctrl_q;
    else if (is_sts)  rd_byte = sts_q;
    else if (in_cfg)  rd_byte = cfg_o[{cfg_idx, 3'b000} +: 8];
    else if (in_mon)  rd_byte = mon_byte;
    else              rd_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (rd_act) rdata_q <= rd_byte;
  end

  assign rdata_o = rdata_q;

  // ---------------- alarm output ----------------
  logic alarm_q, alarm_oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q    <= ~CTRL_DEFAULT[0];
      alarm_oe_q <= CTRL_DEFAULT[1];
    end else begin
      alarm_q    <= los_i ? ctrl_q[0] : ~ctrl_q[0];
      alarm_oe_q <= los_i | ctrl_q[1];
    end
  end

  assign alarm_o    = alarm_q;
  assign alarm_oe_o = alarm_oe_q;

  assert_undef_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_act && !defined) |=> (rdata_o == 8'h00));

  assert_id_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_act && is_id) |=> (rdata_o == ID_VALUE));

  assert_enabled_on_loss_R9: assert property (@(posedge clk) disable iff (rst)
    los_i |=> alarm_oe_o);

  assert_level_on_loss_R9: assert property (@(posedge clk) disable iff (rst)
    los_i |=> (alarm_o == $past(ctrl_q[0])));

  assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> $stable(rdata_o));

endmodule

// File: tb/test_regbank_top.sv
module test_regbank_top;

  localparam int          AW    = 5;
  localparam int          CB    = 3;
  localparam int          MB    = 4;
  localparam int          A_ID  = 0;
  localparam int          A_CT  = 1;
  localparam int          A_CF  = 4;
  localparam int          A_ST  = 8;
  localparam int          A_MN  = 12;
  localparam logic [7:0]  IDV   = 8'h6B;
  localparam logic [7:0]  CTD   = 8'h01;
  localparam logic [23:0] CFD   = 24'hA53C01;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          wr_en, rd_en;
  logic [7:0]    wdata, rdata, evt;
  logic          los;
  logic [31:0]   mon;
  logic [23:0]   cfg;
  logic          alarm, alarm_oe;

  always #2.5 clk = ~clk;

  regbank_top #(
    .ADDR_W(AW), .ID_ADDR(A_ID), .CTRL_ADDR(A_CT), .CFG_BASE(A_CF), .CFG_BYTES(CB),
    .STS_ADDR(A_ST), .MON_BASE(A_MN), .MON_BYTES(MB), .ID_VALUE(IDV),
    .CTRL_DEFAULT(CTD), .CFG_DEFAULT(CFD)
  ) i_regbank_top (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .los_i(los), .mon_i(mon),
    .cfg_o(cfg), .alarm_o(alarm), .alarm_oe_o(alarm_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  logic [7:0]  m_ctrl, m_sts, m_rd;
  logic [23:0] m_cfg;
  logic [7:0]  m_stage [0:2];
  int          m_next;
  logic        m_frozen;
  logic [31:0] m_snap;
  logic        g_los;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [AW-1:0] a, input logic [31:0] live);
    int k;
    if (a == A_ID) return IDV;
    if (a == A_CT) return m_ctrl;
    if (a == A_ST) return m_sts;
    if (a >= A_CF && a < A_CF + CB) begin
      k = int'(a) - A_CF;
      return m_cfg[k*8 +: 8];
    end
    if (a >= A_MN && a < A_MN + MB) begin
      k = int'(a) - A_MN;
      if (k != 0 && m_frozen) return m_snap[k*8 +: 8];
      return live[k*8 +: 8];
    end
    return 8'h00;
  endfunction

  function automatic string tag_for(input logic [AW-1:0] a);
    if (a == A_ID) return "R10";
    if (a == A_CT) return "R2";
    if (a == A_ST) return "R7";
    if (a >= A_CF && a < A_CF + CB) return "R3/R4";
    if (a >= A_MN && a < A_MN + MB) return "R5/R6";
    return "R8";
  endfunction

  task automatic model_update(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                              input logic [7:0] ev, input logic [31:0] live);
    int k;
    logic [7:0] clr;
    if (op == 1 && a >= A_CF && a < A_CF + CB) begin
      k = int'(a) - A_CF;
      if (k == m_next) begin
        if (k == CB - 1) begin
          m_cfg  = {d, m_stage[1], m_stage[0]};
          m_next = 0;
        end else begin
          m_stage[k] = d;
          m_next     = k + 1;
        end
      end else if (k == 0) begin
        m_stage[0] = d;
        m_next     = 1;
      end else begin
        m_next = 0;
      end
    end else if (op != 0) begin
      m_next = 0;
    end
    if (op == 2 && a >= A_MN && a < A_MN + MB) begin
      k = int'(a) - A_MN;
      if (k == 0) begin
        m_frozen = 1'b1;
        m_snap   = live;
      end else if (k == MB - 1) begin
        m_frozen = 1'b0;
      end
    end else if (op != 0) begin
      m_frozen = 1'b0;
    end
    clr   = (op == 1 && a == A_ST) ? d : 8'h00;
    m_sts = (m_sts & ~clr) | ev;
    if (op == 1 && a == A_CT) m_ctrl = d;
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic step(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [7:0] ev, input string tag);
    logic [31:0] live;
    logic [7:0]  exp_rd;
    logic        exp_al, exp_oe;
    live   = $urandom();
    addr   = a;
    wr_en  = (op == 1);
    rd_en  = (op == 2);
    wdata  = d;
    evt    = ev;
    los    = g_los;
    mon    = live;
    exp_al = g_los ? m_ctrl[0] : ~m_ctrl[0];
    exp_oe = g_los | m_ctrl[1];
    exp_rd = (op == 2) ? model_read(a, live) : m_rd;
    model_update(op, a, d, ev, live);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    evt   = 8'h00;
    m_rd  = exp_rd;
    if (op == 2) chk(rdata == exp_rd, tag, {24'h0, rdata}, {24'h0, exp_rd});
    chk(cfg == m_cfg, "R3/R4 cfg value", {8'h0, cfg}, {8'h0, m_cfg});
    chk({alarm, alarm_oe} == {exp_al, exp_oe}, "R9 alarm", {30'h0, alarm, alarm_oe},
        {30'h0, exp_al, exp_oe});
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    step(1, AW'(a), d, 8'h00, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(2, AW'(a), 8'h00, 8'h00, tag);
  endtask
  task automatic idle(input logic [7:0] ev);
    step(0, '0, 8'h00, ev, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wdata = 0; evt = 0; los = 0; mon = 0;
    g_los = 1'b0;
    m_ctrl = CTD; m_sts = 0; m_rd = 0; m_cfg = CFD; m_next = 0; m_frozen = 0; m_snap = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at the ports
    chk(rdata == 8'h00, "R1 rdata", {24'h0, rdata}, 32'h0);
    chk(cfg == CFD, "R1 cfg", {8'h0, cfg}, {8'h0, CFD});
    chk({alarm, alarm_oe} == 2'b00, "R1 alarm", {30'h0, alarm, alarm_oe}, 32'h0);
    rd(A_CT, "R1 ctrl default");
    chk(rdata == CTD, "R1 ctrl literal", {24'h0, rdata}, {24'h0, CTD});
    rd(A_ST, "R1 flags clear");
    rd(A_ID, "R10 id");
    chk(rdata == IDV, "R10 id literal", {24'h0, rdata}, {24'h0, IDV});

    // R2: full-byte replacement
    wr(A_CT, 8'hF6, "R2");
    rd(A_CT, "R2 readback");
    chk(rdata == 8'hF6, "R2 literal", {24'h0, rdata}, 32'hF6);

    // R3: in-order sequence with idle gaps commits on the top byte only
    wr(A_CF + 0, 8'h11, "R3");
    idle(8'h00);
    wr(A_CF + 1, 8'h22, "R3");
    chk(cfg == CFD, "R3 no early commit", {8'h0, cfg}, {8'h0, CFD});
    idle(8'h00);
    wr(A_CF + 2, 8'h33, "R3");
    chk(cfg == 24'h332211, "R3 commit literal", {8'h0, cfg}, 32'h332211);
    rd(A_CF + 1, "R3 readback");

    // R4: interrupted by a read, then out of order, then restart mid-sequence
    wr(A_CF + 0, 8'hAA, "R4");
    rd(A_CT, "R4 interrupting read");
    wr(A_CF + 1, 8'hBB, "R4");
    wr(A_CF + 2, 8'hCC, "R4");
    chk(cfg == 24'h332211, "R4 discarded", {8'h0, cfg}, 32'h332211);
    wr(A_CF + 0, 8'h01, "R4");
    wr(A_CF + 2, 8'h03, "R4 out of order");
    chk(cfg == 24'h332211, "R4 out of order kept", {8'h0, cfg}, 32'h332211);
    wr(A_CF + 0, 8'h44, "R4");
    wr(A_CF + 1, 8'h55, "R4");
    wr(A_CF + 0, 8'h77, "R4 restart");
    wr(A_CF + 1, 8'h88, "R4");
    wr(A_CF + 2, 8'h99, "R4");
    chk(cfg == 24'h998877, "R4 restart literal", {8'h0, cfg}, 32'h998877);

    // R5 and R6: coherent capture and its release
    rd(A_MN + 0, "R5 arm");
    idle(8'h00);
    rd(A_MN + 2, "R5 captured");
    rd(A_MN + 1, "R5 captured");
    rd(A_MN + 3, "R5 captured top");
    rd(A_MN + 2, "R6 live after top read");
    rd(A_MN + 0, "R5 arm");
    rd(A_CT, "R6 outside access");
    rd(A_MN + 1, "R6 live after outside read");
    rd(A_MN + 0, "R5 arm");
    wr(A_MN + 1, 8'h5A, "R6 write releases");
    rd(A_MN + 1, "R6 live after write");

    // R7: sticky flags, write-one-to-clear, event wins
    idle(8'h05);
    idle(8'h00);
    rd(A_ST, "R7 sticky");
    chk(rdata == 8'h05, "R7 literal set", {24'h0, rdata}, 32'h05);
    step(1, AW'(A_ST), 8'h05, 8'h01, "R7 clear with event");
    rd(A_ST, "R7 event wins");
    chk(rdata == 8'h01, "R7 literal event wins", {24'h0, rdata}, 32'h01);
    wr(A_ST, 8'hFE, "R7 zero keeps");
    rd(A_ST, "R7 zero keeps");

    // R8: undefined addresses and read-only addresses
    wr(20, 8'hFF, "R8");
    wr(A_ID, 8'h00, "R8");
    rd(20, "R8 undefined read");
    rd(A_ID, "R8 id unchanged");
    rd(A_CT, "R8 ctrl unchanged");
    rd(A_CF + 0, "R8 cfg unchanged");

    // R9: polarity and drive combinations
    wr(A_CT, 8'h00, "R9");
    idle(8'h00);
    g_los = 1'b1;
    idle(8'h00);
    idle(8'h00);
    chk({alarm, alarm_oe} == 2'b01, "R9 low active", {30'h0, alarm, alarm_oe}, 32'h1);
    g_los = 1'b0;
    wr(A_CT, 8'h03, "R9");
    idle(8'h00);
    chk({alarm, alarm_oe} == 2'b01, "R9 driven inactive", {30'h0, alarm, alarm_oe}, 32'h1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      int k;
      logic [7:0] ev;
      r  = int'($urandom() % 8);
      ev = (($urandom() % 5) == 0) ? 8'($urandom()) : 8'h00;
      if (($urandom() % 16) == 0) g_los = ~g_los;
      case (r)
        0, 1, 2: begin
          k = (($urandom() % 4) == 0) ? int'($urandom() % CB) : m_next;
          step(1, AW'(A_CF + k), 8'($urandom()), ev, "R3/R4 random");
        end
        3: begin
          logic [AW-1:0] a;
          a = AW'($urandom() % 32);
          step(2, a, 8'h00, ev, tag_for(a));
        end
        4: step(2, AW'(A_MN + int'($urandom() % MB)), 8'h00, ev, "R5/R6 random");
        5: step(1, (($urandom() % 2) == 0) ? AW'(A_CT) : AW'(A_ST), 8'($urandom()), ev, "R2/R7 random");
        6: step(0, '0, 8'h00, ev, "idle");
        default: begin
          logic [AW-1:0] a;
          a = AW'($urandom() % 32);
          step(1, a, 8'($urandom()), ev, "R8 random");
        end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule